// File: doc/BRIEF.md
# Wavefront Memory Address Coalescer

This block sits between a wavefront's address generation and the data cache. One memory instruction of a wavefront yields up to 64 load addresses, one per work-item, each fetching a 32-bit word. The block merges the work-items whose addresses fall in the same 64-byte cache block. It then emits one request per distinct block. Each request carries the block-aligned address and a 64-bit mask of the work-items that the block serves.

Addresses enter as four beats of 16 lanes, each lane with its own enable bit. Once the fourth beat is taken, the block stops accepting input. It emits one request per cycle on a valid/ready output in order of the lowest lane each block serves. It takes the next wavefront only after the last request has been accepted. When the lanes read consecutive words from a 64-byte aligned base, each group of 16 lanes becomes exactly one request.

Top module: `wave_coalescer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A wavefront is taken as four beats on `in_valid && in_ready`. Beat k carries lanes 16k to 16k+15, with lane j of the beat at bits [32j+31:32j] of `in_addr` and bit j of `in_lane_en`.
- R3: `out_addr` is a lane's byte address with bits [5:0] cleared. Two lanes share a request exactly when their address bits [31:6] are equal.
- R4: Bit i of `out_mask` is set exactly when lane i is enabled and its address lies in that request's block. Each enabled lane appears in exactly one request of its wavefront, and every request has at least one mask bit set.
- R5: Requests leave in ascending order of the lowest lane index that each one serves.
- R6: A lane whose enable bit is 0 neither creates a request nor appears in any mask, whatever its address.
- R7: Sixteen enabled lanes that read consecutive 32-bit words from a 64-byte aligned base give exactly one request.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_mask` hold their values.
- R9: `in_ready` is 0 from the cycle after the fourth beat until the cycle after the last request is accepted. No request is shown while `in_ready` is 1.
- R10: A wavefront whose 64 enabled lanes all fall in distinct blocks gives 64 requests.
- R11: A wavefront with no enabled lane gives no request, and `in_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat of addresses is offered |
| in_ready | output | 1 | Block takes a beat this cycle |
| in_addr | input | 512 | Sixteen 32-bit byte addresses, lane 0 in the low bits |
| in_lane_en | input | 16 | Per-lane enable for the beat |
| out_valid | output | 1 | A block request is presented |
| out_ready | input | 1 | Consumer accepts the request |
| out_addr | output | 32 | Block-aligned byte address |
| out_mask | output | 64 | Work-items served by this block |

## Verification
A wrong pending mask or a wrong leader choice shows at the ports on the next accepted request. It appears as a lane that is missing or repeated, a request out of order, or a wrong number of requests before `in_ready` returns. A broken tag compare splits or merges blocks, which the bench sees in the first request of a wavefront. A faulty beat counter puts lanes in the wrong beat, so their masks land in the wrong quarter of the 64-bit field. A faulty handshake shows either as a request that changes while stalled or as `in_ready` rising while requests are still owed.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_EMIT = 1'b1
  } wc_state_t;
endpackage

// File: rtl/wc_capture.sv
module wc_capture #(
  parameter int LANES    = 16,
  parameter int BEATS    = 4,
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 6,
  localparam int WAVE    = LANES * BEATS,
  localparam int TAG_W   = ADDR_W - BLK_LOG2,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [LANES*ADDR_W-1:0] beat_addr,
  output logic [WAVE*TAG_W-1:0]   tags_flat,
  output logic [BEAT_W-1:0]       beat_idx,
  output logic                    last_beat
);
  logic [TAG_W-1:0] tag_q [WAVE];

  assign last_beat = (int'(beat_idx) == BEATS - 1);

  always_ff @(posedge clk) begin
    if (rst) beat_idx <= '0;
    else if (take) beat_idx <= last_beat ? '0 : beat_idx + 1'b1;
  end

  // tag store: one row of LANES entries per beat, no reset
  always_ff @(posedge clk) begin
    if (take) begin
      for (int l = 0; l < LANES; l++)
        tag_q[int'(beat_idx) * LANES + l] <= beat_addr[l*ADDR_W + BLK_LOG2 +: TAG_W];
    end
  end

  for (genvar g = 0; g < WAVE; g++) begin : g_flat
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
    take && last_beat |=> beat_idx == '0); // R2
endmodule

// File: rtl/wc_match.sv
module wc_match #(
  parameter int WAVE  = 64,
  parameter int TAG_W = 26,
  localparam int IDX_W = $clog2(WAVE)
) (
  input  logic [WAVE*TAG_W-1:0] tags_flat,
  input  logic [WAVE-1:0]       pending,
  output logic [TAG_W-1:0]      lead_tag,
  output logic [WAVE-1:0]       hit_mask,
  output logic                  any_pending
);
  logic [IDX_W-1:0] lead_idx;

  // lowest pending lane is the leader
  always_comb begin
    lead_idx = '0;
    for (int i = WAVE - 1; i >= 0; i--)
      if (pending[i]) lead_idx = IDX_W'(i);
  end

  assign lead_tag    = tags_flat[int'(lead_idx)*TAG_W +: TAG_W];
  assign any_pending = |pending;

  for (genvar g = 0; g < WAVE; g++) begin : g_cmp
    assign hit_mask[g] = pending[g] && (tags_flat[g*TAG_W +: TAG_W] == lead_tag);
  end
endmodule

// File: rtl/wave_coalescer.sv
module wave_coalescer #(
  parameter int LANES    = 16,
  parameter int BEATS    = 4,
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 6,
  localparam int WAVE    = LANES * BEATS,
  localparam int TAG_W   = ADDR_W - BLK_LOG2,
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_lane_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [WAVE-1:0]         out_mask
);
  import wc_pkg::*;

  wc_state_t             state;
  logic [WAVE-1:0]       pending;
  logic [WAVE*TAG_W-1:0] tags_flat;
  logic [BEAT_W-1:0]     beat_idx;
  logic                  last_beat;
  logic [TAG_W-1:0]      lead_tag;
  logic [WAVE-1:0]       hit_mask;
  logic                  any_pending;
  logic                  take;
  logic                  slot_free;

  assign in_ready  = (state == ST_LOAD);
  assign take      = in_valid && in_ready;
  assign slot_free = !out_valid || out_ready;

  wc_capture #(.LANES(LANES), .BEATS(BEATS), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_capture (
    .clk(clk), .rst(rst), .take(take), .beat_addr(in_addr),
    .tags_flat(tags_flat), .beat_idx(beat_idx), .last_beat(last_beat)
  );

  wc_match #(.WAVE(WAVE), .TAG_W(TAG_W)) u_match (
    .tags_flat(tags_flat), .pending(pending), .lead_tag(lead_tag),
    .hit_mask(hit_mask), .any_pending(any_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      pending   <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_mask  <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (take) begin
            pending[int'(beat_idx)*LANES +: LANES] <= in_lane_en;
            if (last_beat) state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (slot_free) begin
            if (any_pending) begin
              out_valid <= 1'b1;
              out_addr  <= {lead_tag, {BLK_LOG2{1'b0}}};
              out_mask  <= hit_mask;
              pending   <= pending & ~hit_mask;
            end else begin
              out_valid <= 1'b0;
              state     <= ST_LOAD;
            end
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask)); // R8
  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_addr[BLK_LOG2-1:0] == '0); // R3
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mask != '0); // R4
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid || ((out_mask & $past(out_mask)) == '0)); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R9
  AST_HIT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (hit_mask & ~pending) == '0); // R6
endmodule

// File: tb/wave_coalescer_test.sv
module wave_coalescer_test;
  localparam int LANES = 16;
  localparam int BEATS = 4;
  localparam int WAVE  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*32-1:0] in_addr = '0;
  logic [LANES-1:0] in_lane_en = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [63:0] out_mask;

  always #5 clk = ~clk;

  wave_coalescer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_lane_en(in_lane_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_mask(out_mask)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] wa [WAVE];
  logic [63:0] we;
  logic [31:0] exp_addr [WAVE];
  logic [63:0] exp_mask [WAVE];
  int exp_n;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] stride;
    logic [63:0] en;
    logic [7:0]  n;
    logic        rev;
    logic        stall;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'd4,   64'hFFFF_FFFF_FFFF_FFFF, 8'd4,  1'b0, 1'b0}, // R3 R4
    '{32'h0002_0000, 32'd64,  64'hFFFF_FFFF_FFFF_FFFF, 8'd64, 1'b0, 1'b0}, // R10
    '{32'h0000_3010, 32'd0,   64'hFFFF_FFFF_FFFF_FFFF, 8'd1,  1'b0, 1'b0}, // R3
    '{32'h0000_1004, 32'd4,   64'hFFFF_FFFF_FFFF_FFFF, 8'd5,  1'b0, 1'b0}, // R3 unaligned
    '{32'h0000_1000, 32'd4,   64'h0,                   8'd0,  1'b0, 1'b0}, // R11
    '{32'h0000_0040, 32'd4,   64'h0000_0000_0000_FFFF, 8'd1,  1'b0, 1'b0}, // R7
    '{32'h0000_8000, 32'd128, 64'h5555_5555_5555_5555, 8'd32, 1'b0, 1'b0}, // R6
    '{32'h0000_4000, 32'd4,   64'hFFFF_FFFF_FFFF_FFFF, 8'd4,  1'b1, 1'b0}, // R5
    '{32'h0000_1000, 32'd32,  64'hFFFF_FFFF_FFFF_FFFF, 8'd32, 1'b0, 1'b1}  // R8
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // reference: walk lanes upward, each new enabled block gathers all enabled lanes sharing bits [31:6]
  task automatic build_model();
    logic [63:0] used = '0;
    exp_n = 0;
    for (int i = 0; i < WAVE; i++) begin
      if (we[i] && !used[i]) begin
        exp_addr[exp_n] = {wa[i][31:6], 6'b0};
        exp_mask[exp_n] = '0;
        for (int j = i; j < WAVE; j++)
          if (we[j] && wa[j][31:6] == wa[i][31:6]) exp_mask[exp_n][j] = 1'b1;
        used = used | exp_mask[exp_n];
        exp_n++;
      end
    end
  endtask

  task automatic send_wave();
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        in_addr[l*32 +: 32] = wa[b*LANES + l];
        in_lane_en[l] = we[b*LANES + l];
      end
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R9 in_ready after fourth beat", 64'(in_ready), 64'd0);
  endtask

  task automatic collect(input bit stall, input int n_table);
    int got = 0;
    bit held = 1'b0;
    logic [31:0] ha = '0;
    logic [63:0] hm = '0;
    for (int g = 0; g < 3000; g++) begin
      if (g > 0) @(negedge clk);
      if (held)
        check(out_valid && out_addr == ha && out_mask == hm, "R8 request held under stall",
              {out_addr, 32'(out_valid)}, {ha, 32'd1});
      held = 1'b0;
      out_ready = stall ? (g % 3 == 2) : 1'b1;
      if (out_valid && in_ready)
        check(1'b0, "R9 request shown while in_ready", 64'd1, 64'd0);
      if (out_valid && !out_ready) begin
        held = 1'b1; ha = out_addr; hm = out_mask;
      end else if (out_valid && out_ready) begin
        if (got < exp_n) begin
          check(out_addr == exp_addr[got], "R3 R5 block address", 64'(out_addr), 64'(exp_addr[got]));
          check(out_mask == exp_mask[got], "R4 R6 lane mask", out_mask, exp_mask[got]);
        end else begin
          check(1'b0, "R4 extra request", 64'(got), 64'(exp_n));
        end
        got++;
      end else if (in_ready && !out_valid) begin
        break;
      end
    end
    out_ready = 1'b1;
    check(got == exp_n, "R10 R11 request count vs model", 64'(got), 64'(exp_n));
    check(got == n_table, "R7 R10 request count vs table", 64'(got), 64'(n_table));
    check(in_ready == 1'b1, "R9 in_ready after last request", 64'(in_ready), 64'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);

    // table walk, R2 beat order is exercised by every entry
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < WAVE; i++)
        wa[i] = VECS[v].rev ? VECS[v].base + 32'(WAVE - 1 - i) * VECS[v].stride
                            : VECS[v].base + 32'(i) * VECS[v].stride;
      we = VECS[v].en;
      build_model();
      send_wave();
      collect(VECS[v].stall, int'(VECS[v].n));
    end

    // R6: a disabled lane with a unique address must not create a request
    for (int i = 0; i < WAVE; i++) wa[i] = 32'h0000_5000 + 32'(i % 16) * 4;
    wa[37] = 32'h0000_9000;
    we = ~(64'd1 << 37);
    build_model();
    send_wave();
    collect(1'b0, 1);

    // R2: beat placement, one lane per beat in its own block
    for (int i = 0; i < WAVE; i++) wa[i] = 32'h0001_0000 + 32'(i) * 64;
    we = 64'h0001_0000_0000_0000 | 64'h0000_0001_0000_0000 | 64'h0000_0000_0001_0000 | 64'h1;
    build_model();
    send_wave();
    collect(1'b0, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule